// File: doc/BRIEF.md
# Synchronous DRAM Command Decoder and Bank Tracker

This block watches the control pins of a four-bank synchronous DRAM and keeps track of what the pins have done to the banks. On every rising clock edge it samples the clock enable, the chip select, the three active-low strobes, a 12-bit address and a 2-bit bank number. It turns them into one of seven command kinds. It keeps an open flag and the open row for each bank, and it reports each accepted command one cycle later, together with its row, its column and any auto-precharge request.

The block suits a controller's shadow state, a protocol monitor or a behavioural memory front end. Address bit 10 serves two purposes. On a read or a write it asks for auto-precharge. On a precharge it selects every bank. The column width follows the `DQ_WIDTH` parameter: 10 bits for 4-bit data, 9 for 8-bit and 8 for 16-bit. The tracker marks a bank closed as soon as it accepts a read or write that carries auto-precharge, so the bank is treated as closing from that point on.

Top module: `sdram_ctl_tracker`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `bank_open` is 0, every entry of `open_rows` is 0, and `cmd_valid`, `err_pulse` and `err_sticky` are 0.
- R2: An activate ({ras_n,cas_n,we_n}=011) to a closed bank opens that bank on the next cycle, stores `addr` as its row in `open_rows[bank*12 +: 12]`, and reports `cmd_row` = `addr`.
- R3: While `cs_n` is high, no command is taken: `cmd_valid` and `err_pulse` are 0 on the next cycle, and `bank_open`, `open_rows` and `err_sticky` stay the same.
- R4: While `cke` is low, no command is taken, whatever the other inputs are. The outputs behave exactly as in R3.
- R5: A read (101) or a write (100) to an open bank with `addr[10]` low reports `cmd_col` = `addr[COL_W-1:0]` and `cmd_row` = the row open in that bank. It leaves the bank open and raises no error.
- R6: A read or write to an open bank with `addr[10]` high sets `cmd_autopre` and closes that bank on the next cycle. It leaves the other banks unchanged.
- R7: A precharge (010) with `addr[10]` high closes all four banks, whatever `bank` holds. With `addr[10]` low it closes only the bank that `bank` selects.
- R8: A read or write to a closed bank, or an activate to an open bank, raises `err_pulse` for one cycle and sets `err_sticky`. It changes neither `bank_open` nor `open_rows`.
- R9: An auto-refresh (001) is accepted without an error only when all banks are closed. If any bank is open it raises `err_pulse` and sets `err_sticky`.
- R10: `cmd_code` reports 1 for activate, 2 read, 3 write, 4 precharge, 5 auto-refresh and 6 mode-register-set (000). The codes 111 and 110 are no-operations: they give `cmd_valid` 0 and change no state.
- R11: Every output for a command appears in the cycle after the clock edge that sampled it. `err_sticky` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low stops command sampling |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Row on activate; column and bit-10 flag on read, write and precharge |
| bank | input | 2 | Bank number |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 48 | Stored row per bank, bank n at bits n*12 +: 12 |
| cmd_valid | output | 1 | A non-NOP command was sampled last cycle |
| cmd_code | output | 3 | Kind of the reported command |
| cmd_bank | output | 2 | Bank of the reported command |
| cmd_row | output | 12 | Activated row, or the stored row of the addressed bank |
| cmd_col | output | COL_W | Column of a read or write, else 0 |
| cmd_autopre | output | 1 | Legal read or write that carried auto-precharge |
| err_pulse | output | 1 | Last sampled command was illegal |
| err_sticky | output | 1 | An illegal command has been seen since reset |

## Verification
Directed sequences first open, read and close banks in fixed orders. They issue a precharge with bit 10 both high and low against a mix of open banks, which tells a single-bank close apart from an all-bank close. They also repeat an activate and issue a refresh with one bank still open, which separates legal commands from illegal ones. A long random run then mixes every strobe code with random banks and addresses while `cs_n` and `cke` toggle. This shows whether deselected or frozen cycles leak into the bank state, and whether the column and row fields come from the right address bits and the right bank.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [2:0] {
    K_NOP = 3'd0,
    K_ACT = 3'd1,
    K_RD  = 3'd2,
    K_WR  = 3'd3,
    K_PRE = 3'd4,
    K_REF = 3'd5,
    K_MRS = 3'd6
  } cmd_kind_e;

  // Strobe triple {ras_n,cas_n,we_n} to command kind; unlisted codes act as NOP.
  function automatic cmd_kind_e decode_strobes(input logic ras_n, input logic cas_n,
                                               input logic we_n);
    cmd_kind_e k;
    case ({ras_n, cas_n, we_n})
      3'b011:  k = K_ACT;
      3'b101:  k = K_RD;
      3'b100:  k = K_WR;
      3'b010:  k = K_PRE;
      3'b001:  k = K_REF;
      3'b000:  k = K_MRS;
      default: k = K_NOP;
    endcase
    return k;
  endfunction

  // Column address width from the data width of the organisation.
  function automatic int col_bits(input int dq_width);
    int w;
    case (dq_width)
      4:       w = 10;
      8:       w = 9;
      default: w = 8;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
  import sdc_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ROW_W  = 12,
  parameter int AP_BIT = 10,
  localparam int BANK_W = $clog2(NB)
) (
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ROW_W-1:0]  addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [NB-1:0]     open_vec,
  output cmd_kind_e         kind,
  output logic              sampled,
  output logic              illegal,
  output logic              act_en,
  output logic              autopre,
  output logic [NB-1:0]     close_mask
);

  logic          sel_open;
  logic          ap_flag;
  logic          is_rw;
  logic [NB-1:0] sel_onehot;

  always_comb begin
    sampled    = cke & ~cs_n;
    kind       = decode_strobes(ras_n, cas_n, we_n);
    sel_open   = open_vec[bank];
    ap_flag    = addr[AP_BIT];
    sel_onehot = NB'(1) << bank;
    is_rw      = (kind == K_RD) || (kind == K_WR);

    illegal = 1'b0;
    if (sampled) begin
      if (is_rw && !sel_open)                 illegal = 1'b1;
      else if (kind == K_ACT && sel_open)      illegal = 1'b1;
      else if (kind == K_REF && (|open_vec))   illegal = 1'b1;
    end

    act_en  = sampled && (kind == K_ACT) && !illegal;
    autopre = sampled && is_rw && !illegal && ap_flag;

    close_mask = '0;
    if (sampled && kind == K_PRE)
      close_mask = ap_flag ? {NB{1'b1}} : sel_onehot;
    else if (autopre)
      close_mask = sel_onehot;
  end

endmodule

// File: rtl/sdc_bank_state.sv
module sdc_bank_state #(
  parameter int NB    = 4,
  parameter int ROW_W = 12,
  localparam int BANK_W = $clog2(NB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                act_en,
  input  logic [BANK_W-1:0]   act_bank,
  input  logic [ROW_W-1:0]    act_row,
  input  logic [NB-1:0]       close_mask,
  output logic [NB-1:0]       open_vec,
  output logic [NB*ROW_W-1:0] rows_flat
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             open_q, open_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic             hit;

    always_comb begin
      hit    = act_en && (act_bank == BANK_W'(b));
      open_d = open_q;
      row_d  = row_q;
      if (hit) begin
        open_d = 1'b1;
        row_d  = act_row;
      end else if (close_mask[b]) begin
        open_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else begin
        open_q <= open_d;
        if (hit) row_q <= row_d;
      end
    end

    assign open_vec[b]                   = open_q;
    assign rows_flat[b*ROW_W +: ROW_W]   = row_q;
  end

endmodule

// File: rtl/sdram_ctl_tracker.sv
module sdram_ctl_tracker
  import sdc_pkg::*;
#(
  parameter int DQ_WIDTH = 16,
  parameter int NB       = 4,
  parameter int ROW_W    = 12,
  localparam int BANK_W  = $clog2(NB),
  localparam int COL_W   = col_bits(DQ_WIDTH),
  localparam int AP_BIT  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [ROW_W-1:0]    addr,
  input  logic [BANK_W-1:0]   bank,
  output logic [NB-1:0]       bank_open,
  output logic [NB*ROW_W-1:0] open_rows,
  output logic                cmd_valid,
  output logic [2:0]          cmd_code,
  output logic [BANK_W-1:0]   cmd_bank,
  output logic [ROW_W-1:0]    cmd_row,
  output logic [COL_W-1:0]    cmd_col,
  output logic                cmd_autopre,
  output logic                err_pulse,
  output logic                err_sticky
);

  cmd_kind_e     kind;
  logic          sampled, illegal, act_en, autopre;
  logic [NB-1:0] close_mask;

  sdc_cmd_decode #(.NB(NB), .ROW_W(ROW_W), .AP_BIT(AP_BIT)) dec_i (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .bank(bank), .open_vec(bank_open),
    .kind(kind), .sampled(sampled), .illegal(illegal), .act_en(act_en),
    .autopre(autopre), .close_mask(close_mask)
  );

  sdc_bank_state #(.NB(NB), .ROW_W(ROW_W)) banks_i (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .act_bank(bank),
    .act_row(addr), .close_mask(close_mask),
    .open_vec(bank_open), .rows_flat(open_rows)
  );

  // Report stage: next-state logic
  logic              valid_d, errp_d, errs_d, ap_d;
  logic [2:0]        code_d;
  logic [BANK_W-1:0] bank_d;
  logic [ROW_W-1:0]  row_d;
  logic [COL_W-1:0]  col_d;
  logic              load_en;
  logic              is_rw;

  always_comb begin
    is_rw   = (kind == K_RD) || (kind == K_WR);
    load_en = sampled;
    valid_d = sampled && (kind != K_NOP);
    errp_d  = illegal;
    errs_d  = err_sticky | illegal;
    ap_d    = autopre;
    code_d  = kind;
    bank_d  = bank;
    row_d   = (kind == K_ACT) ? addr : open_rows[bank*ROW_W +: ROW_W];
    col_d   = is_rw ? addr[COL_W-1:0] : '0;
  end

  // Report stage: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      err_pulse   <= 1'b0;
      err_sticky  <= 1'b0;
      cmd_autopre <= 1'b0;
      cmd_code    <= '0;
      cmd_bank    <= '0;
      cmd_row     <= '0;
      cmd_col     <= '0;
    end else begin
      cmd_valid  <= valid_d;
      err_pulse  <= errp_d;
      err_sticky <= errs_d;
      if (load_en) begin
        cmd_autopre <= ap_d;
        cmd_code    <= code_d;
        cmd_bank    <= bank_d;
        cmd_row     <= row_d;
        cmd_col     <= col_d;
      end
    end
  end

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int NB = 4,
  localparam int BANK_W = $clog2(NB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              ap_bit,
  input logic [BANK_W-1:0] bank,
  input logic [NB-1:0]     bank_open,
  input logic              cmd_valid,
  input logic              err_pulse,
  input logic              err_sticky
);

  logic       take;
  logic [2:0] strobes;
  assign take    = cke && !cs_n;
  assign strobes = {ras_n, cas_n, we_n};

  a_r3_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!cmd_valid && !err_pulse && $stable(bank_open)));

  a_r4_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (!cmd_valid && !err_pulse && $stable(bank_open)));

  a_r2_activate_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (take && strobes == 3'b011 && !bank_open[bank]) |=> bank_open[$past(bank)]);

  a_r7_close_all: assert property (@(posedge clk) disable iff (!rst_n)
    (take && strobes == 3'b010 && ap_bit) |=> (bank_open == '0));

  a_r8_closed_access: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (strobes == 3'b101 || strobes == 3'b100) && !bank_open[bank])
      |=> (err_pulse && $stable(bank_open)));

  a_r9_refresh_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (take && strobes == 3'b001 && (|bank_open)) |=> err_pulse);

  a_r11_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  a_r11_sticky_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_sticky) |-> 1'b0);

endmodule

bind sdram_ctl_tracker sdc_checker #(.NB(NB)) chk_i (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ap_bit(addr[10]), .bank(bank),
  .bank_open(bank_open), .cmd_valid(cmd_valid), .err_pulse(err_pulse),
  .err_sticky(err_sticky)
);

// File: tb/sdram_ctl_tracker_tb_top.sv
module sdram_ctl_tracker_tb_top;

  localparam int COL_W = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [11:0] addr;
  logic [1:0]  bank;
  logic [3:0]  bank_open;
  logic [47:0] open_rows;
  logic        cmd_valid, cmd_autopre, err_pulse, err_sticky;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_row;
  logic [COL_W-1:0] cmd_col;

  always #5 clk = ~clk;

  sdram_ctl_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .bank(bank),
    .bank_open(bank_open), .open_rows(open_rows), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_autopre(cmd_autopre), .err_pulse(err_pulse),
    .err_sticky(err_sticky)
  );

  int n_checks = 0;
  int n_fails  = 0;

  // Reference model
  logic        m_open [4];
  logic [11:0] m_row  [4];
  logic        m_sticky;

  function automatic int code_of(logic [2:0] s);
    case (s)
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return 4;
      3'b001: return 5;
      3'b000: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [47:0] model_rows();
    logic [47:0] v;
    for (int i = 0; i < 4; i++) v[i*12 +: 12] = m_row[i];
    return v;
  endfunction

  function automatic logic [3:0] model_open();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = m_open[i];
    return v;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 1'b0;
      m_row[i]  = '0;
    end
    m_sticky = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    addr = '0; bank = '0;
    model_reset();
    @(negedge clk);
    // R1: reset state while held
    check("R1", {7'd0, cmd_valid, err_pulse, err_sticky, bank_open, open_rows},
          64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {7'd0, cmd_valid, err_pulse, err_sticky, bank_open, open_rows},
          64'd0);
  endtask

  task automatic issue(input logic e, input logic cs, input logic [2:0] s,
                       input logic [11:0] a, input logic [1:0] b);
    int          k;
    logic        smp, ill, rw, ap;
    logic        e_valid;
    logic [11:0] e_row;
    logic [COL_W-1:0] e_col;
    string       tag;
    logic        any_open;

    cke = e; cs_n = cs; {ras_n, cas_n, we_n} = s; addr = a; bank = b;
    k   = code_of(s);
    smp = e && !cs;
    rw  = (k == 2) || (k == 3);
    any_open = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    ill = smp && ((rw && !m_open[b]) || (k == 1 && m_open[b]) || (k == 5 && any_open));
    ap  = smp && rw && !ill && a[10];
    e_valid = smp && (k != 0);
    e_row = (k == 1) ? a : m_row[b];
    e_col = rw ? a[COL_W-1:0] : '0;

    if (!e)                tag = "R4";
    else if (cs)           tag = "R3";
    else if (ill)          tag = "R8";
    else if (k == 1)       tag = "R2";
    else if (rw && a[10])  tag = "R6";
    else if (rw)           tag = "R5";
    else if (k == 4)       tag = "R7";
    else if (k == 5)       tag = "R9";
    else                   tag = "R10";

    if (smp && !ill) begin
      if (k == 1) begin
        m_open[b] = 1'b1;
        m_row[b]  = a;
      end else if (k == 4) begin
        if (a[10]) for (int i = 0; i < 4; i++) m_open[i] = 1'b0;
        else m_open[b] = 1'b0;
      end else if (ap) begin
        m_open[b] = 1'b0;
      end
    end
    if (ill) m_sticky = 1'b1;

    @(posedge clk);
    @(negedge clk);
    // R11: results appear one cycle after the sampling edge
    check(tag, {7'd0, cmd_valid, err_pulse, err_sticky, bank_open, open_rows},
          {7'd0, e_valid, ill, m_sticky, model_open(), model_rows()});
    if (e_valid)
      check(tag, {40'd0, cmd_code, cmd_bank, cmd_row, cmd_col, cmd_autopre},
            {40'd0, 3'(k), b, e_row, e_col, ap});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    do_reset();

    // R2 open two banks
    issue(1, 0, 3'b011, 12'h5A3, 2'd1);
    issue(1, 0, 3'b011, 12'hFFF, 2'd3);
    // R5 read/write without auto-precharge
    issue(1, 0, 3'b101, 12'h0C7, 2'd1);
    issue(1, 0, 3'b100, 12'h2FE, 2'd3);
    // R8 activate on open bank, read on closed bank
    issue(1, 0, 3'b011, 12'h111, 2'd1);
    issue(1, 0, 3'b101, 12'h010, 2'd0);
    // R3 deselected activate, R4 frozen precharge-all
    issue(1, 1, 3'b011, 12'h222, 2'd0);
    issue(0, 0, 3'b010, 12'h400, 2'd0);
    // R10 no-op codes and mode set
    issue(1, 0, 3'b110, 12'h400, 2'd1);
    issue(1, 0, 3'b111, 12'h000, 2'd1);
    issue(1, 0, 3'b000, 12'h033, 2'd2);
    // R9 refresh with banks open
    issue(1, 0, 3'b001, 12'h000, 2'd0);
    // R7 single-bank precharge with A10 low
    issue(1, 0, 3'b010, 12'h000, 2'd3);
    // R6 write with auto-precharge closes bank 1
    issue(1, 0, 3'b100, 12'h4AB, 2'd1);
    issue(1, 0, 3'b101, 12'h001, 2'd1);
    // R7 precharge-all with bank bits pointing at a closed bank
    issue(1, 0, 3'b011, 12'h0A0, 2'd0);
    issue(1, 0, 3'b011, 12'h0B0, 2'd2);
    issue(1, 0, 3'b010, 12'h400, 2'd3);
    // R9 refresh with all closed
    issue(1, 0, 3'b001, 12'h000, 2'd0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic       e, cs;
      logic [2:0] s;
      int         pick;
      e    = ($urandom % 10) != 0;
      cs   = ($urandom % 8) == 0;
      pick = $urandom % 10;
      case (pick)
        0, 1, 2: s = 3'b011;
        3, 4:    s = 3'b101;
        5:       s = 3'b100;
        6:       s = 3'b010;
        7:       s = 3'b001;
        8:       s = 3'b000;
        default: s = 3'($urandom);
      endcase
      issue(e, cs, s, 12'($urandom), 2'($urandom));
    end

    // R1 reset in mid-run clears state and sticky error
    do_reset();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule